// File: doc/BRIEF.md
# Unified Load/Store Ordering Queue

This block keeps every in-flight memory operation of an out-of-order core, loads and stores together, in one circular queue in program order. It decides when each load may be sent to the data cache. It never speculates. A load is released only when every store ahead of it in program order has a resolved effective address and none of those addresses equals the load's own address. Stores leave the queue only at retirement, and they are written out from the head of the queue in program order.

The queue is used through five interfaces:

- **Dispatch** allocates an entry at the tail and returns its slot number.
- **Address writeback** fills in an entry's effective address, in whatever order the address units finish.
- **Load issue** presents at most one released load per cycle.
- **Commit** retires the head entry. A retiring store appears on the store-write port.
- **Flush** discards every entry that has not retired.

Data values, the cache and address translation are outside the block.

Top module: `lsq_unified`

## Requirements
- R1: Dispatch takes the slot at the tail and returns its number on `disp_idx` in the same cycle. Slot numbers rise by one per accepted dispatch and wrap from DEPTH-1 to 0. `disp_full` is high when DEPTH entries are held, and a dispatch seen while it is high is dropped. `q_empty` is high when no entry is held.
- R2: An address writeback names a slot. It sets that entry's address and marks the address known from the next cycle. A writeback to a slot that holds no entry has no effect, even after a later dispatch reuses that slot.
- R3: A load with a known address may issue only when every older store in the queue has a known address and no older store address equals the load address (all ADDR_W bits compared).
- R4: Stores younger than a load, and other loads of any age, never hold that load back.
- R5: `ld_go` is asserted in the same cycle that a load becomes eligible. At most one load issues per cycle, and it is the eligible load nearest the head in program order. A load issues once only.
- R6: With `commit` high and the queue not empty, the head entry retires. A retiring store drives `st_wr_valid` high with its address on `st_wr_addr` in that same cycle. A retiring load writes nothing. `commit` on an empty queue has no effect.
- R7: `flush` empties the queue, so `q_empty` is high in the next cycle. A commit in the same cycle still retires the head first. A dispatch in the flush cycle is dropped.
- R8: After reset the queue is empty, not full, and neither `ld_go` nor `st_wr_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_is_store | input | 1 | Dispatched operation is a store (1) or a load (0) |
| disp_idx | output | IDX_W | Slot that a dispatch in this cycle receives |
| disp_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entry |
| agen_valid | input | 1 | Address writeback strobe |
| agen_idx | input | IDX_W | Slot being written |
| agen_addr | input | ADDR_W | Effective address |
| ld_go | output | 1 | A load is released to the cache this cycle |
| ld_go_idx | output | IDX_W | Slot of the released load |
| ld_go_addr | output | ADDR_W | Address of the released load |
| commit | input | 1 | Retire the head entry |
| st_wr_valid | output | 1 | A store retires this cycle |
| st_wr_addr | output | ADDR_W | Address of the retiring store |
| flush | input | 1 | Discard all unretired entries |

## Verification
The in-RTL assertions check several properties on every cycle:

- The occupancy stays within DEPTH and agrees with the pointer gap.
- The head entry is never held back.
- At most one load is granted.
- An issued load is a valid load with a known address, and it is marked issued afterwards.
- A retiring store has a resolved address.
- A flush leaves the queue empty.

Other properties need the bench's scenarios and its program-order reference model:

- Only a matching or unresolved older store blocks a load, and a younger one never does.
- The oldest eligible load wins across a wrap of the pointers.
- A stray writeback to a free slot is lost.
- A commit in the same cycle as a flush still writes out its store.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   typedef struct packed {
      logic valid;
      logic is_store;
      logic addr_ok;
      logic issued;
   } lsq_flags_t;
endpackage

// File: rtl/lsq_ring_ptrs.sv
module lsq_ring_ptrs #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic             retire,
   input  logic             flush,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic             full,
   output logic             empty
);
   logic [IDX_W:0]   count;
   logic [IDX_W-1:0] head_nx;

   assign head_nx = head + IDX_W'(retire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head <= head_nx;
         if (flush) begin
            tail  <= head_nx;
            count <= '0;
         end else begin
            tail  <= tail + IDX_W'(alloc);
            count <= count + (IDX_W+1)'(alloc) - (IDX_W+1)'(retire);
         end
      end
   end

   assign full  = (count == (IDX_W+1)'(DEPTH));
   assign empty = (count == '0);

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (IDX_W+1)'(DEPTH));
   p_ptr_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !full |-> (IDX_W'(count) == IDX_W'(tail - head)));
   p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/lsq_dep_matrix.sv
module lsq_dep_matrix #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W-1:0]       head,
   input  lsq_pkg::lsq_flags_t    flags [DEPTH],
   input  logic [ADDR_W-1:0]      addr  [DEPTH],
   output logic [DEPTH-1:0]       blocked
);
   logic [IDX_W-1:0] age [DEPTH];
   logic [DEPTH-1:0] hazard [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      assign age[k] = IDX_W'(k) - head;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      for (genvar j = 0; j < DEPTH; j++) begin : g_col
         if (i == j) begin : g_self
            assign hazard[i][j] = 1'b0;
         end else begin : g_pair
            logic older, unsafe;
            assign older  = age[j] < age[i];
            assign unsafe = !flags[j].addr_ok || (addr[j] == addr[i]);
            assign hazard[i][j] = flags[j].valid && flags[j].is_store && older && unsafe;
         end
      end
      assign blocked[i] = |hazard[i];
   end

   p_head_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flags[head].valid |-> !blocked[head]);
endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] req,
   input  logic [IDX_W-1:0] head,
   output logic [DEPTH-1:0] gnt,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx
);
   logic [IDX_W-1:0] pos;

   always_comb begin
      gnt       = '0;
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      pos       = '0;
      for (int o = 0; o < DEPTH; o++) begin
         pos = head + IDX_W'(o);
         if (!gnt_valid && req[pos]) begin
            gnt[pos]  = 1'b1;
            gnt_valid = 1'b1;
            gnt_idx   = pos;
         end
      end
   end

   p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_grant_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> req[gnt_idx]);
endmodule

// File: rtl/lsq_unified.sv
module lsq_unified #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic              disp_is_store,
   output logic [IDX_W-1:0]  disp_idx,
   output logic              disp_full,
   output logic              q_empty,
   input  logic              agen_valid,
   input  logic [IDX_W-1:0]  agen_idx,
   input  logic [ADDR_W-1:0] agen_addr,
   output logic              ld_go,
   output logic [IDX_W-1:0]  ld_go_idx,
   output logic [ADDR_W-1:0] ld_go_addr,
   input  logic              commit,
   output logic              st_wr_valid,
   output logic [ADDR_W-1:0] st_wr_addr,
   input  logic              flush
);
   import lsq_pkg::*;

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("lsq_unified: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("lsq_unified: ADDR_W must be positive");
   end

   lsq_flags_t        flg [DEPTH];
   logic [ADDR_W-1:0] adr [DEPTH];
   logic [IDX_W-1:0]  head, tail;
   logic [DEPTH-1:0]  blocked, eligible, gnt;
   logic              alloc, retire;

   assign retire = commit && !q_empty;
   assign alloc  = disp_valid && !disp_full && !flush;

   lsq_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire), .flush(flush),
      .head(head), .tail(tail), .full(disp_full), .empty(q_empty)
   );

   lsq_dep_matrix #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_deps (
      .clk(clk), .rst_n(rst_n), .head(head), .flags(flg), .addr(adr),
      .blocked(blocked)
   );

   for (genvar k = 0; k < DEPTH; k++) begin : g_elig
      assign eligible[k] = flg[k].valid && !flg[k].is_store && flg[k].addr_ok &&
                           !flg[k].issued && !blocked[k];
   end

   lsq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
      .clk(clk), .rst_n(rst_n), .req(eligible), .head(head),
      .gnt(gnt), .gnt_valid(ld_go), .gnt_idx(ld_go_idx)
   );

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flg[k] <= '0;
            adr[k] <= '0;
         end else if (flush) begin
            flg[k] <= '0;
         end else if (retire && head == IDX_W'(k)) begin
            flg[k] <= '0;
         end else if (alloc && tail == IDX_W'(k)) begin
            flg[k] <= '{valid: 1'b1, is_store: disp_is_store, addr_ok: 1'b0, issued: 1'b0};
         end else begin
            if (agen_valid && agen_idx == IDX_W'(k) && flg[k].valid) begin
               flg[k].addr_ok <= 1'b1;
               adr[k]         <= agen_addr;
            end
            if (gnt[k]) begin
               flg[k].issued <= 1'b1;
            end
         end
      end
   end

   assign disp_idx    = tail;
   assign ld_go_addr  = adr[ld_go_idx];
   assign st_wr_valid = retire && flg[head].is_store;
   assign st_wr_addr  = adr[head];

   p_issue_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_go |-> (flg[ld_go_idx].valid && !flg[ld_go_idx].is_store && flg[ld_go_idx].addr_ok));
   p_issue_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_go && !flush && !(retire && ld_go_idx == head)) |=> flg[$past(ld_go_idx)].issued);
   p_store_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_valid |-> (flg[head].valid && flg[head].addr_ok));
   p_store_at_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_valid |-> commit);
endmodule

// File: tb/lsq_unified_tb_top.sv
module lsq_unified_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DEPTH  = 8;
   localparam int ADDR_W = 16;
   localparam int IDX_W  = $clog2(DEPTH);

   typedef struct {
      int idx;
      bit st;
      bit known;
      int addr;
      bit issued;
   } ment_t;

   logic clk = 0, rst_n = 0;
   logic disp_valid = 0, disp_is_store = 0, agen_valid = 0, commit = 0, flush = 0;
   logic [IDX_W-1:0]  agen_idx = '0;
   logic [ADDR_W-1:0] agen_addr = '0;
   logic [IDX_W-1:0]  disp_idx, ld_go_idx;
   logic              disp_full, q_empty, ld_go, st_wr_valid;
   logic [ADDR_W-1:0] ld_go_addr, st_wr_addr;

   int total = 0, bad = 0;
   bit done = 0;
   ment_t mq[$];
   int head_m = 0, tail_m = 0;
   bit s_go, s_st;
   int s_idx, s_addr, s_waddr;

   always #2.5 clk = ~clk;

   lsq_unified #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_store(disp_is_store),
      .disp_idx(disp_idx), .disp_full(disp_full), .q_empty(q_empty),
      .agen_valid(agen_valid), .agen_idx(agen_idx), .agen_addr(agen_addr),
      .ld_go(ld_go), .ld_go_idx(ld_go_idx), .ld_go_addr(ld_go_addr),
      .commit(commit), .st_wr_valid(st_wr_valid), .st_wr_addr(st_wr_addr), .flush(flush)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // position in mq of the oldest load that the rules allow to issue, or -1
   function automatic int exp_issue_pos();
      for (int p = 0; p < mq.size(); p++) begin
         if (!mq[p].st && mq[p].known && !mq[p].issued) begin
            bit ok = 1;
            for (int q = 0; q < p; q++)
               if (mq[q].st && (!mq[q].known || mq[q].addr == mq[p].addr)) ok = 0;
            if (ok) return p;
         end
      end
      return -1;
   endfunction

   // one clock: drive after negedge, compare, then advance the model at posedge
   task automatic step(input bit dv, input bit ds, input bit av, input int ai, input int aa,
                       input bit cm, input bit fl);
      int ep, sz;
      bit exp_full, exp_st;
      @(negedge clk);
      disp_valid = dv; disp_is_store = ds; agen_valid = av;
      agen_idx = IDX_W'(ai); agen_addr = ADDR_W'(aa); commit = cm; flush = fl;
      #1;
      sz = mq.size();
      ep = exp_issue_pos();
      exp_full = (sz == DEPTH);
      exp_st = cm && sz > 0 && mq[0].st;
      chk(disp_full == exp_full, "R1 full", disp_full, exp_full);
      chk(q_empty == (sz == 0), "R1 empty", q_empty, sz == 0);
      if (!exp_full) chk(int'(disp_idx) == tail_m, "R1 disp_idx", disp_idx, tail_m);
      chk(ld_go == (ep >= 0), "R3 ld_go", ld_go, ep >= 0);
      if (ep >= 0 && ld_go) begin
         chk(int'(ld_go_idx) == mq[ep].idx, "R5 ld_go_idx", ld_go_idx, mq[ep].idx);
         chk(int'(ld_go_addr) == mq[ep].addr, "R5 ld_go_addr", ld_go_addr, mq[ep].addr);
      end
      chk(st_wr_valid == exp_st, "R6 st_wr_valid", st_wr_valid, exp_st);
      if (exp_st && st_wr_valid)
         chk(int'(st_wr_addr) == mq[0].addr, "R6 st_wr_addr", st_wr_addr, mq[0].addr);
      s_go = ld_go; s_idx = int'(ld_go_idx); s_addr = int'(ld_go_addr);
      s_st = st_wr_valid; s_waddr = int'(st_wr_addr);
      @(posedge clk);
      if (ep >= 0) mq[ep].issued = 1;
      if (av)
         foreach (mq[p]) if (mq[p].idx == ai) begin mq[p].known = 1; mq[p].addr = aa; end
      if (cm && sz > 0) begin
         void'(mq.pop_front());
         head_m = (head_m + 1) % DEPTH;
      end
      if (fl) begin
         mq.delete();
         tail_m = head_m;
      end else if (dv && sz < DEPTH) begin
         mq.push_back('{idx: tail_m, st: ds, known: 0, addr: 0, issued: 0});
         tail_m = (tail_m + 1) % DEPTH;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic disp(input bit st);
      step(1, st, 0, 0, 0, 0, 0);
   endtask
   task automatic agen(input int i, input int a);
      step(0, 0, 1, i, a, 0, 0);
   endtask
   task automatic retire1();
      step(0, 0, 0, 0, 0, 1, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int ia, ib;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R8 reset state
      chk(q_empty == 1, "R8 empty", q_empty, 1);
      chk(disp_full == 0, "R8 full", disp_full, 0);
      chk(ld_go == 0, "R8 ld_go", ld_go, 0);
      chk(st_wr_valid == 0, "R8 st_wr", st_wr_valid, 0);
      rst_n = 1;
      idle(1);
      retire1();                       // R6 commit on empty: no effect
      chk(s_st == 0, "R6 commit empty", s_st, 0);

      // lone load
      disp(0); agen(0, 'h10); idle(1);
      chk(s_go == 1 && s_idx == 0, "R5 lone load issue", s_idx, 0);
      retire1();

      // R3 older unknown store blocks, resolves to different address
      disp(1); disp(0); agen(2, 'h20); idle(2);
      chk(s_go == 0, "R3 unknown older store blocks", s_go, 0);
      agen(1, 'h30); idle(1);
      chk(s_go == 1 && s_idx == 2, "R3 release after resolve", s_idx, 2);
      retire1();
      chk(s_st == 1 && s_waddr == 'h30, "R6 store write", s_waddr, 'h30);
      retire1();

      // R3 matching older store holds load until it retires
      disp(1); agen(3, 'h40); disp(0); agen(4, 'h40); idle(2);
      chk(s_go == 0, "R3 matching store blocks", s_go, 0);
      retire1(); idle(1);
      chk(s_go == 1 && s_idx == 4, "R3 release after store retire", s_idx, 4);
      retire1();

      // R4 younger unknown store does not block
      disp(0); disp(1); agen(5, 'h50); idle(1);
      chk(s_go == 1 && s_idx == 5, "R4 younger store ignored", s_idx, 5);
      agen(6, 'h50); retire1(); retire1();

      // R5 oldest pick across wrap (head=7)
      disp(1); disp(0); disp(0); disp(0);
      agen(2, 'h61); agen(1, 'h62); agen(0, 'h63);
      agen(7, 'h70); chk(s_go == 0, "R3 all blocked", s_go, 0);
      idle(1); chk(s_go == 1 && s_idx == 0, "R5 oldest first", s_idx, 0);
      idle(1); chk(s_go == 1 && s_idx == 1, "R5 second", s_idx, 1);
      idle(1); chk(s_go == 1 && s_idx == 2, "R5 third", s_idx, 2);
      idle(1); chk(s_go == 0, "R5 issue once", s_go, 0);

      // fill to full, overflow dispatch dropped
      for (int i = 0; i < 5; i++) disp(i % 2);
      disp(0); disp(0);
      chk(mq.size() == DEPTH, "R1 full occupancy", mq.size(), DEPTH);
      // R7 flush with commit: head store writes out, queue empties
      step(1, 0, 0, 0, 0, 1, 1);
      chk(s_st == 1 && s_waddr == 'h70, "R7 commit during flush", s_waddr, 'h70);
      @(negedge clk); #1;
      chk(q_empty == 1, "R7 empty after flush", q_empty, 1);

      // R2 writeback to free slot ignored
      ia = tail_m;
      agen(ia, 'h77); disp(0); idle(2);
      chk(s_go == 0, "R2 stray writeback ignored", s_go, 0);
      agen(ia, 'h78); idle(1);
      chk(s_go == 1 && s_addr == 'h78, "R2 writeback applies", s_addr, 'h78);
      retire1();

      // random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         bit dv, ds, av, cm, fl;
         int ai, aa, ncand;
         int cand[$];
         dv = ($urandom_range(0, 9) < 6);
         ds = $urandom_range(0, 1);
         foreach (mq[p]) if (!mq[p].known) cand.push_back(mq[p].idx);
         ncand = cand.size();
         av = (ncand > 0) && ($urandom_range(0, 9) < 7);
         ai = av ? cand[$urandom_range(0, ncand - 1)] : 0;
         aa = $urandom_range(0, 3);
         cm = mq.size() > 0 && (mq[0].st ? mq[0].known : mq[0].issued) && $urandom_range(0, 1);
         fl = ($urandom_range(0, 99) < 2);
         step(dv, ds, av, ai, aa, cm, fl);
      end
      ib = 0;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad + ib);
      $finish;
   end
endmodule